// File: doc/BRIEF.md
# SPI Flash Lower-Bound Access Guard

This block sits on the request path between a host command source and an SPI flash sequencer. Every request carries a 24-bit flash address and a kind: a software-programmed command or a memory-mapped read. The guard compares the upper sixteen address bits against a programmable floor held in a base register. A request at or above the floor passes straight through with a valid/ready handshake. A request below the floor is consumed and dropped, never reaches the sequencer, and raises a violation pulse and a sticky error flag.

Software programs the floor through a simple 32-bit register port. It sets the region size by writing ones into the upper bits that do not matter for its flash. The hardware compares the field exactly as written and does not mask it. A floor of zero lets every request through. The floor cannot be changed once a lock-down input has been seen: the lock stays set until a full reset. The floor and the lock belong to the sticky domain. A core reset clears only the error flag and the violation pulse.

Register map (word index on `reg_addr`): index 0 is the base register, index 1 is the status register, and any other index reads as zero.

Top module: `flash_floor_guard`

## Requirements
- R1: Index 0 reads back the floor in bits 23:8. Bits 31:24 and 7:0 read as zero whatever was written to them.
- R2: When `req_addr[23:8]` is greater than or equal to the floor, the guard forwards the request in the same cycle: `out_valid` = `req_valid`, `req_ready` = `out_ready`, and `out_addr`/`out_kind` equal `req_addr`/`req_kind`.
- R3: When `req_addr[23:8]` is below the floor, `out_valid` stays 0 and `req_ready` is 1, so the request is consumed and dropped.
- R4: `viol_pulse` is 1 for exactly the cycle after each cycle in which a refused request was presented. It is never 1 after a passing request.
- R5: Status bit 0 is an error flag. A refused request sets it, and writing 1 to bit 0 at index 1 clears it. When a refusal and a clear arrive in the same cycle, the refusal wins.
- R6: Once `lock_in` has been seen high, status bit 1 reads 1 until `rst_n` is asserted, and writes to index 0 leave the floor unchanged.
- R7: After `rst_n`, the floor is 0, status reads 0, and every address, including 000000h, passes.
- R8: `core_rst_n` clears the error flag and the violation pulse, but leaves the floor and the lock unchanged.
- R9: Programmed commands (`req_kind`=0) and memory reads (`req_kind`=1) are checked against the same floor in the same way.
- R10: Address bits 7:0 take no part in the check. With floor 0001h, address 0000FFh is refused and 000100h passes. Addresses 000000h and 000001h pass only when the floor is 0.
- R11: The floor is compared with no masking. With floor FFFFh, address FFFEFFh is refused and FFFF00h passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full reset, active low; clears the sticky domain too |
| core_rst_n | input | 1 | Core reset, active low; clears only non-sticky state |
| lock_in | input | 1 | Lock-down request; its effect holds until rst_n |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Upstream request ready |
| req_addr | input | 24 | Upstream flash address |
| req_kind | input | 1 | 0 = programmed command, 1 = memory read |
| out_valid | output | 1 | Downstream request valid |
| out_ready | input | 1 | Downstream request ready |
| out_addr | output | 24 | Downstream flash address |
| out_kind | output | 1 | Downstream request kind |
| viol_pulse | output | 1 | One-cycle pulse after a refused request |

## Verification
The assertions check on every cycle that nothing below the floor ever reaches the downstream side, that refused requests are always consumed, that a violation pulse only follows a refused request and is matched by the error flag, and that a locked floor neither unlocks nor changes. Some behaviour can only be shown by the bench scenarios: the exact boundary at the low byte, the unmasked all-ones floor, the error flag winning over a clear in the same cycle, and the sticky floor and lock surviving a core reset while a full reset clears them. The bench also runs a seeded random mix of floors, addresses, kinds and downstream stalls against its own model.

// File: rtl/floor_pkg.sv
package floor_pkg;
   localparam int unsigned DEF_REG_W   = 32;
   localparam int unsigned DEF_ADDR_W  = 24;
   localparam int unsigned DEF_FIELD_LO = 8;
   localparam int unsigned DEF_IDX_W   = 2;

   // register word indices
   localparam logic [DEF_IDX_W-1:0] IDX_BASE = 2'd0;
   localparam logic [DEF_IDX_W-1:0] IDX_STAT = 2'd1;

   // status bit positions
   localparam int unsigned STAT_ERR  = 0;
   localparam int unsigned STAT_LOCK = 1;

   typedef enum logic {
      KIND_PROG = 1'b0,
      KIND_MEMRD = 1'b1
   } req_kind_e;
endpackage

// File: rtl/floor_base_reg.sv
module floor_base_reg #(
   parameter int unsigned FIELD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lock_in,
   input  logic               wr_en,
   input  logic [FIELD_W-1:0] wr_field,
   output logic [FIELD_W-1:0] base_q,
   output logic               lock_q
);
   // sticky domain: only the full reset touches these
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
      end else if (lock_in) begin
         lock_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (wr_en && !lock_q) begin
         base_q <= wr_field;
      end
   end
endmodule

// File: rtl/floor_cmp.sv
module floor_cmp #(
   parameter int unsigned FIELD_W     = 16,
   parameter bit          USE_BORROW  = 1'b0
) (
   input  logic [FIELD_W-1:0] addr_hi,
   input  logic [FIELD_W-1:0] base,
   output logic               at_or_above
);
   generate
      if (USE_BORROW) begin : g_borrow
         logic [FIELD_W:0] diff;
         always_comb begin
            diff        = {1'b0, addr_hi} - {1'b0, base};
            at_or_above = ~diff[FIELD_W];
         end
      end else begin : g_mag
         always_comb begin
            at_or_above = (addr_hi >= base);
         end
      end
   endgenerate
endmodule

// File: rtl/floor_gate.sv
module floor_gate #(
   parameter int unsigned ADDR_W = 24
) (
   input  logic              clk,
   input  logic              soft_rst_n,
   input  logic              pass,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_kind,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_kind,
   input  logic              err_clr,
   output logic              err_q,
   output logic              viol_q
);
   logic refuse;

   always_comb begin
      refuse    = req_valid && !pass;
      out_valid = req_valid && pass;
      req_ready = pass ? out_ready : 1'b1;
      out_addr  = req_addr;
      out_kind  = req_kind;
   end

   always_ff @(posedge clk or negedge soft_rst_n) begin
      if (!soft_rst_n) begin
         viol_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         viol_q <= refuse;
         if (refuse) begin
            err_q <= 1'b1;
         end else if (err_clr) begin
            err_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/flash_floor_guard.sv
module flash_floor_guard
   import floor_pkg::*;
#(
   parameter int unsigned REG_W      = DEF_REG_W,
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned FIELD_LO   = DEF_FIELD_LO,
   parameter int unsigned IDX_W      = DEF_IDX_W,
   parameter bit          USE_BORROW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_rst_n,
   input  logic              lock_in,
   input  logic              reg_wen,
   input  logic [IDX_W-1:0]  reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_kind,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_kind,
   output logic              viol_pulse
);
   localparam int unsigned FIELD_W = ADDR_W - FIELD_LO;

   initial begin
      assert (ADDR_W < REG_W) else $error("ADDR_W must be below REG_W");
      assert (FIELD_LO >= 2 && FIELD_LO < ADDR_W) else $error("FIELD_LO out of range");
      assert (IDX_W >= 1) else $error("IDX_W must be at least 1");
   end

   logic [FIELD_W-1:0] base_q;
   logic               lock_q;
   logic               err_q;
   logic               pass;
   logic               soft_rst_n;
   logic               base_wr;
   logic               err_clr;
   logic               unused_wbits;

   assign soft_rst_n = rst_n & core_rst_n;
   assign base_wr    = reg_wen && (reg_addr == IDX_W'(IDX_BASE));
   assign err_clr    = reg_wen && (reg_addr == IDX_W'(IDX_STAT)) && reg_wdata[STAT_ERR];
   assign unused_wbits = ^{reg_wdata[REG_W-1:ADDR_W], reg_wdata[FIELD_LO-1:1]};

   floor_base_reg #(.FIELD_W(FIELD_W)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_in  (lock_in),
      .wr_en    (base_wr),
      .wr_field (reg_wdata[ADDR_W-1:FIELD_LO]),
      .base_q   (base_q),
      .lock_q   (lock_q)
   );

   floor_cmp #(.FIELD_W(FIELD_W), .USE_BORROW(USE_BORROW)) u_cmp (
      .addr_hi     (req_addr[ADDR_W-1:FIELD_LO]),
      .base        (base_q),
      .at_or_above (pass)
   );

   floor_gate #(.ADDR_W(ADDR_W)) u_gate (
      .clk        (clk),
      .soft_rst_n (soft_rst_n),
      .pass       (pass),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_kind   (req_kind),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_addr   (out_addr),
      .out_kind   (out_kind),
      .err_clr    (err_clr),
      .err_q      (err_q),
      .viol_q     (viol_pulse)
   );

   // read mux: reserved bits are zero
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == IDX_W'(IDX_BASE)) begin
         reg_rdata[ADDR_W-1:FIELD_LO] = base_q;
      end else if (reg_addr == IDX_W'(IDX_STAT)) begin
         reg_rdata[STAT_ERR]  = err_q;
         reg_rdata[STAT_LOCK] = lock_q;
      end
   end
endmodule

// File: rtl/floor_guard_chk.sv
module floor_guard_chk #(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned FIELD_LO = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        core_rst_n,
   input logic                        req_valid,
   input logic                        req_ready,
   input logic                        out_valid,
   input logic                        out_ready,
   input logic [ADDR_W-1:0]           out_addr,
   input logic                        viol_pulse,
   input logic [ADDR_W-FIELD_LO-1:0]  base_q,
   input logic                        lock_q,
   input logic                        err_q
);
   // R2: nothing under the floor is ever issued
   a_r2_floor_held: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
      out_valid |-> (out_addr[ADDR_W-1:FIELD_LO] >= base_q));

   // R2: forwarding mirrors the handshake
   a_r2_handshake: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
      out_valid |-> (req_valid && (req_ready == out_ready)));

   // R3: a refused request is consumed
   a_r3_refused_consumed: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
      (req_valid && !out_valid) |-> req_ready);

   // R4: a pulse only follows a refusal
   a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
      viol_pulse |-> $past(req_valid && !out_valid));

   // R5: a pulse is always matched by the error flag
   a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
      viol_pulse |-> err_q);

   // R6: the lock never drops without a full reset
   a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R6: a locked floor does not move
   a_r6_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(base_q));
endmodule

bind flash_floor_guard floor_guard_chk #(.ADDR_W(ADDR_W), .FIELD_LO(FIELD_LO)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .core_rst_n (core_rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_addr   (out_addr),
   .viol_pulse (viol_pulse),
   .base_q     (base_q),
   .lock_q     (lock_q),
   .err_q      (err_q)
);

// File: tb/sim_flash_floor_guard.sv
module sim_flash_floor_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_rst_n = 1'b1;
   logic        lock_in = 1'b0;
   logic        reg_wen = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_addr = '0;
   logic        req_kind = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [23:0] out_addr;
   logic        out_kind;
   logic        viol_pulse;

   int checks = 0;
   int errors = 0;
   logic [15:0] mdl_base = '0;
   bit          mdl_err  = 1'b0;
   bit          mdl_lock = 1'b0;

   always #2 clk = ~clk;

   flash_floor_guard u0 (
      .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n), .lock_in(lock_in),
      .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_kind(req_kind),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_kind(out_kind),
      .viol_pulse(viol_pulse)
   );

   function automatic bit f_pass(logic [15:0] base, logic [23:0] a);
      return a[23:8] >= base;
   endfunction

   function automatic logic [31:0] f_base_rd(logic [15:0] base);
      return {8'h00, base, 8'h00};
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] idx, logic [31:0] d);
      @(negedge clk);
      reg_wen = 1'b1; reg_addr = idx; reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0;
      if (idx == 2'd0 && !mdl_lock) mdl_base = d[23:8];
      if (idx == 2'd1 && d[0]) mdl_err = 1'b0;
   endtask

   task automatic rd_chk(logic [1:0] idx, logic [31:0] exp, string tag);
      reg_addr = idx;
      #1;
      chk(reg_rdata === exp, tag, reg_rdata, exp);
   endtask

   task automatic req(logic [23:0] a, logic k, logic ordy, string tag);
      bit p;
      p = f_pass(mdl_base, a);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_kind = k; out_ready = ordy;
      #1;
      chk(out_valid === p, {tag, " out_valid"}, 32'(out_valid), 32'(p));
      chk(req_ready === (p ? ordy : 1'b1), {tag, " req_ready"}, 32'(req_ready), 32'(p ? ordy : 1'b1));
      if (p) chk(out_addr === a && out_kind === k, {tag, " payload R2"}, {7'd0, out_kind, out_addr}, {7'd0, k, a});
      @(negedge clk);
      req_valid = 1'b0;
      if (!p) mdl_err = 1'b1;
      #1;
      chk(viol_pulse === !p, {tag, " viol R4"}, 32'(viol_pulse), 32'(!p));
   endtask

   task automatic full_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      mdl_base = '0; mdl_err = 1'b0; mdl_lock = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7 reset state
      rd_chk(2'd0, 32'h0, "R7 base after reset");
      rd_chk(2'd1, 32'h0, "R7 status after reset");
      req(24'h000000, 1'b0, 1'b1, "R7 zero address passes");

      // R1 reserved bits
      wr(2'd0, 32'hFFFF_FFFF);
      rd_chk(2'd0, 32'h00FF_FF00, "R1 reserved read zero");

      // R11 unmasked compare
      req(24'hFFFEFF, 1'b1, 1'b1, "R11 below all-ones floor");
      req(24'hFFFF00, 1'b1, 1'b0, "R11 at all-ones floor");

      // R10 low byte ignored
      wr(2'd0, 32'h0000_0100);
      req(24'h0000FF, 1'b0, 1'b1, "R10 just below");
      req(24'h000100, 1'b0, 1'b1, "R10 at floor");
      req(24'h000001, 1'b0, 1'b1, "R10 id address refused");
      wr(2'd0, 32'h0);
      req(24'h000001, 1'b0, 1'b1, "R10 id address zero floor");

      // R9 both kinds
      wr(2'd0, 32'h0012_3400);
      req(24'h1233FF, 1'b0, 1'b1, "R9 prog refused");
      req(24'h1233FF, 1'b1, 1'b1, "R9 memrd refused");
      req(24'h123400, 1'b0, 1'b1, "R9 prog pass");
      req(24'h123400, 1'b1, 1'b1, "R9 memrd pass");

      // R3 refused consumed with stalled downstream
      req(24'h000010, 1'b1, 1'b0, "R3 refused stalled");

      // R5 flag set and W1C
      rd_chk(2'd1, 32'h1, "R5 flag set");
      wr(2'd1, 32'h0);
      rd_chk(2'd1, 32'h1, "R5 write zero keeps flag");
      wr(2'd1, 32'h1);
      rd_chk(2'd1, 32'h0, "R5 flag cleared");
      // refusal and clear in the same cycle
      @(negedge clk);
      req_valid = 1'b1; req_addr = 24'h000000; out_ready = 1'b1;
      reg_wen = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1;
      @(negedge clk);
      req_valid = 1'b0; reg_wen = 1'b0;
      mdl_err = 1'b1;
      rd_chk(2'd1, 32'h1, "R5 set wins over clear");

      // R8 core reset keeps sticky state
      @(negedge clk); lock_in = 1'b1;
      @(negedge clk); lock_in = 1'b0; mdl_lock = 1'b1;
      @(negedge clk); core_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      core_rst_n = 1'b1; mdl_err = 1'b0;
      rd_chk(2'd0, f_base_rd(16'h1234), "R8 base survives core reset");
      rd_chk(2'd1, 32'h2, "R8 lock kept, flag cleared");

      // R6 locked writes ignored
      wr(2'd0, 32'h0000_0000);
      rd_chk(2'd0, f_base_rd(16'h1234), "R6 locked base unchanged");
      req(24'h000000, 1'b0, 1'b1, "R6 floor still enforced");
      repeat (3) @(negedge clk);
      rd_chk(2'd1, 32'h3, "R6 lock stays high");
      full_reset();
      rd_chk(2'd1, 32'h0, "R6 full reset clears lock");
      rd_chk(2'd0, 32'h0, "R7 full reset clears base");

      // random mix (R2 R3 R4 R9)
      for (int i = 0; i < 400; i++) begin
         logic [23:0] a;
         if (i % 20 == 0) begin
            int unsigned pick;
            pick = $urandom_range(0, 3);
            wr(2'd0, pick == 0 ? 32'h0 : pick == 1 ? 32'h00FF_FF00 : $urandom());
         end
         a = $urandom();
         if ($urandom_range(0, 3) == 0) a[23:8] = mdl_base - 16'($urandom_range(0, 1));
         req(a, 1'($urandom()), 1'($urandom()), "R2 R3 random");
      end
      rd_chk(2'd1, {30'd0, mdl_lock, mdl_err}, "R5 status after random");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule